// File: doc/BRIEF.md
# Port Test Mode Controller

This block puts a high-speed port into one of its electrical test behaviours when software writes an 8-bit selector value. The selector is decoded into ranges. Two codes start a supported test. A range of standard codes is held back for later tests. A high range is passed to a vendor hook. Every remaining code is refused. A refused code raises a one-cycle error pulse and changes nothing.

In packet-loop mode, the port's transmit byte stream repeats a fixed test packet. The packet comes from a computed internal table, is framed with start and end markers, and has a fixed idle gap between copies. In repeater mode, the downstream ports are force-enabled. Each byte that arrives on the upstream side is copied to the port under test with a fixed latency, and the packet markers are kept. The disconnect-detect input is always available as a registered status bit, so it can be polled while the line loading is changed. Once a test mode is entered, it stays until a synchronous reset.

Top module: `ptm_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_valid`, `tx_sop`, `tx_eop`, `tx_data`, `force_en`, `sel_err`, `vend_stb` and `vend_code` are all zero, and the block is in normal mode.
- R2: A write of 8'h04 in normal mode starts packet-loop mode. From the cycle after the write edge, the stream repeats with a period of PKT_LEN+IDLE_GAP (default 16+8). Byte i of the packet is (29*i+7) mod 256. `tx_sop` marks byte 0 and `tx_eop` marks byte PKT_LEN-1. Then `tx_valid` stays low with `tx_data` zero for IDLE_GAP cycles. Upstream traffic is not forwarded in this mode.
- R3: A write of 8'h05 in normal mode raises `force_en` in the cycle after the write edge. `force_en` stays high until reset and is low in every other mode.
- R4: In repeater mode, the upstream beat (`up_valid`, `up_sop`, `up_eop`, `up_data`) sampled at clock edge n appears on the `tx_*` outputs after edge n+1, with the markers unchanged.
- R5: `disc_status` equals the `disc_in` value sampled at the previous clock edge, in every mode.
- R6: A write of any value from 8'h06 to 8'h3F pulses `sel_err` for exactly one cycle and changes neither the mode nor the outputs.
- R7: In normal mode, a write of any value from 8'hC0 to 8'hFF pulses `vend_stb` for one cycle. It loads `vend_code` with the value, leaves the mode unchanged and does not raise `sel_err`.
- R8: A write of any value from 8'h00 to 8'h03 or from 8'h40 to 8'hBF pulses `sel_err` for one cycle with no other effect.
- R9: While a test mode is active, every selector write, whatever its value, pulses `sel_err`, gives no vendor strobe and leaves the mode unchanged. Only `rst` returns the block to normal mode.
- R10: In normal mode, `tx_valid`, `tx_sop`, `tx_eop` and `tx_data` are zero, and upstream traffic is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_val | input | 8 | Selector value |
| up_valid | input | 1 | Upstream beat valid |
| up_sop | input | 1 | Upstream start of packet |
| up_eop | input | 1 | Upstream end of packet |
| up_data | input | 8 | Upstream byte |
| disc_in | input | 1 | Disconnect-detect input |
| tx_valid | output | 1 | Transmit beat valid |
| tx_sop | output | 1 | Transmit start of packet |
| tx_eop | output | 1 | Transmit end of packet |
| tx_data | output | 8 | Transmit byte |
| force_en | output | 1 | Force-enable of downstream ports |
| disc_status | output | 1 | Registered disconnect status |
| sel_err | output | 1 | One-cycle pulse for a refused selector |
| vend_stb | output | 1 | One-cycle vendor hook strobe |
| vend_code | output | 8 | Last vendor selector value |

## Verification
The bench writes every range edge (03h, 04h, 05h, 06h, 3Fh, 40h, BFh, C0h, FFh). A decoder with an off-by-one range would send a refused code to the vendor hook, or start a test on a reserved code. It also writes selectors while a test is active. A design that is not sticky would switch modes, and one that lets vendor codes through would strobe the hook. Packet-loop mode is followed over several periods, so a wrong gap length or a missing marker shows up as a shifted beat. Repeater mode is fed back-to-back packets and packets with gaps, so a latency of one or three clocks, or dropped markers, shows up on the first beat.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_PKT  = 2'd1,
        MODE_REP  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        CL_PKT,
        CL_REP,
        CL_RSV_STD,
        CL_VEND,
        CL_BAD
    } sel_class_e;

    typedef struct packed {
        logic       valid;
        logic       sop;
        logic       eop;
        logic [7:0] data;
    } beat_t;

    localparam logic [7:0] SEL_PKT      = 8'h04;
    localparam logic [7:0] SEL_REP      = 8'h05;
    localparam logic [7:0] SEL_STD_LAST = 8'h3F;
    localparam logic [7:0] SEL_VEND_LO  = 8'hC0;

    function automatic sel_class_e classify(input logic [7:0] v);
        if (v == SEL_PKT)                        return CL_PKT;
        else if (v == SEL_REP)                   return CL_REP;
        else if (v > SEL_REP && v <= SEL_STD_LAST) return CL_RSV_STD;
        else if (v >= SEL_VEND_LO)               return CL_VEND;
        else                                     return CL_BAD;
    endfunction

    // Test packet content: byte i = 29*i + 7, truncated to 8 bits
    function automatic logic [7:0] pkt_byte(input int unsigned idx);
        int unsigned t;
        t = idx * 29 + 7;
        return t[7:0];
    endfunction

endpackage

// File: rtl/ptm_decode.sv
module ptm_decode
    import ptm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_wr,
    input  logic [7:0] sel_val,
    output mode_e      mode,
    output logic       sel_err,
    output logic       vend_stb,
    output logic [7:0] vend_code
);

    sel_class_e cls;

    always_comb cls = classify(sel_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_NORM;
            sel_err   <= 1'b0;
            vend_stb  <= 1'b0;
            vend_code <= 8'h00;
        end else begin
            sel_err  <= 1'b0;
            vend_stb <= 1'b0;
            if (sel_wr) begin
                if (mode != MODE_NORM) begin
                    sel_err <= 1'b1;
                end else begin
                    unique case (cls)
                        CL_PKT:  mode <= MODE_PKT;
                        CL_REP:  mode <= MODE_REP;
                        CL_VEND: begin
                            vend_stb  <= 1'b1;
                            vend_code <= sel_val;
                        end
                        default: sel_err <= 1'b1;
                    endcase
                end
            end
        end
    end

    // R9: a test mode, once entered, holds until reset
    a_r9_sticky_mode: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_NORM) |=> (mode == $past(mode)));

    // R6: reserved standard codes raise an error and leave the mode alone
    a_r6_reserved_std: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && sel_val > 8'h05 && sel_val < 8'h40) |=> (sel_err && $stable(mode)));

    // R7: vendor strobe and error are never raised together
    a_r7_vend_excl: assert property (@(posedge clk) disable iff (rst)
        !(vend_stb && sel_err));

    // R8: refused low or mid codes never start a test
    a_r8_bad_no_mode: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && (sel_val < 8'h04 || (sel_val > 8'h3F && sel_val < 8'hC0))) |=> (sel_err && $stable(mode)));

endmodule

// File: rtl/ptm_pktgen.sv
module ptm_pktgen
    import ptm_pkg::*;
#(
    parameter int unsigned PKT_LEN  = 16,
    parameter int unsigned IDLE_GAP = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    output beat_t beat
);

    localparam int unsigned PERIOD = PKT_LEN + IDLE_GAP;
    localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);
    localparam logic [CW-1:0] LEN_C  = CW'(PKT_LEN);
    localparam logic [CW-1:0] EOP_C  = CW'(PKT_LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            beat <= '0;
        end else begin
            beat.valid <= (cnt < LEN_C);
            beat.sop   <= (cnt == '0);
            beat.eop   <= (cnt == EOP_C);
            beat.data  <= (cnt < LEN_C) ? pkt_byte(int'(cnt)) : 8'h00;
            cnt        <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
        end
    end

    // R2: markers only ride on valid beats
    a_r2_sop_valid: assert property (@(posedge clk) disable iff (rst)
        (beat.sop || beat.eop) |-> beat.valid);

    // R2: an end marker is followed by the idle gap
    a_r2_gap_after_eop: assert property (@(posedge clk) disable iff (rst)
        (beat.eop && run) |=> !beat.valid);

    // R10: a stopped generator emits nothing
    a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
        !run |=> !beat.valid);

endmodule

// File: rtl/ptm_repeat.sv
module ptm_repeat
    import ptm_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    output beat_t out_beat
);

    beat_t stage [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= in_beat;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign out_beat = stage[DEPTH-1];

endmodule

// File: rtl/ptm_ctrl.sv
module ptm_ctrl
    import ptm_pkg::*;
#(
    parameter int unsigned PKT_LEN  = 16,
    parameter int unsigned IDLE_GAP = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_wr,
    input  logic [7:0] sel_val,
    input  logic       up_valid,
    input  logic       up_sop,
    input  logic       up_eop,
    input  logic [7:0] up_data,
    input  logic       disc_in,
    output logic       tx_valid,
    output logic       tx_sop,
    output logic       tx_eop,
    output logic [7:0] tx_data,
    output logic       force_en,
    output logic       disc_status,
    output logic       sel_err,
    output logic       vend_stb,
    output logic [7:0] vend_code
);

    localparam int unsigned REP_LAT = 2;

    mode_e mode;
    beat_t gen_beat;
    beat_t rep_beat;
    beat_t up_beat;
    beat_t tx_beat;

    ptm_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .sel_wr    (sel_wr),
        .sel_val   (sel_val),
        .mode      (mode),
        .sel_err   (sel_err),
        .vend_stb  (vend_stb),
        .vend_code (vend_code)
    );

    ptm_pktgen #(
        .PKT_LEN  (PKT_LEN),
        .IDLE_GAP (IDLE_GAP)
    ) u_pktgen (
        .clk  (clk),
        .rst  (rst),
        .run  (mode == MODE_PKT),
        .beat (gen_beat)
    );

    always_comb begin
        up_beat.valid = up_valid;
        up_beat.sop   = up_sop;
        up_beat.eop   = up_eop;
        up_beat.data  = up_data;
    end

    ptm_repeat #(
        .DEPTH (REP_LAT)
    ) u_repeat (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (up_beat),
        .out_beat (rep_beat)
    );

    always_comb begin
        unique case (mode)
            MODE_PKT: tx_beat = gen_beat;
            MODE_REP: tx_beat = rep_beat;
            default:  tx_beat = '0;
        endcase
    end

    assign tx_valid = tx_beat.valid;
    assign tx_sop   = tx_beat.sop;
    assign tx_eop   = tx_beat.eop;
    assign tx_data  = tx_beat.data;
    assign force_en = (mode == MODE_REP);

    always_ff @(posedge clk) disc_status <= disc_in;

    // cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)            warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R4: repeated beats come out two clocks after they go in
    a_r4_repeat_latency: assert property (@(posedge clk) disable iff (rst)
        (force_en && warm == 2'd2) |->
            (tx_valid == $past(up_valid, 2) && tx_sop == $past(up_sop, 2) &&
             tx_eop == $past(up_eop, 2) && tx_data == $past(up_data, 2)));

    // R10: nothing is transmitted in normal mode
    a_r10_normal_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORM) |-> (!tx_valid && tx_data == 8'h00));

    // R3: force-enable never drops once raised
    a_r3_force_hold: assert property (@(posedge clk) disable iff (rst)
        force_en |=> force_en);

    // R5: status tracks the detect input by one clock
    a_r5_disc_follow: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0) |-> (disc_status == $past(disc_in)));

endmodule

// File: tb/ptm_ctrl_tb.sv
module ptm_ctrl_tb;

    localparam int LEN = 16;
    localparam int GAP = 8;
    localparam int PER = LEN + GAP;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_wr = 1'b0;
    logic [7:0] sel_val = 8'h00;
    logic       up_valid = 1'b0, up_sop = 1'b0, up_eop = 1'b0;
    logic [7:0] up_data = 8'h00;
    logic       disc_in = 1'b0;
    logic       tx_valid, tx_sop, tx_eop, force_en, disc_status, sel_err, vend_stb;
    logic [7:0] tx_data, vend_code;

    always #2 clk = ~clk;

    ptm_ctrl #(.PKT_LEN(LEN), .IDLE_GAP(GAP)) u_dut (
        .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_val(sel_val),
        .up_valid(up_valid), .up_sop(up_sop), .up_eop(up_eop), .up_data(up_data),
        .disc_in(disc_in), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_data(tx_data), .force_en(force_en), .disc_status(disc_status),
        .sel_err(sel_err), .vend_stb(vend_stb), .vend_code(vend_code)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    string cur_tag = "R8";

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int ref_byte(input int i);
        return (i * 29 + 7) % 256;
    endfunction

    // behavioural reference model
    int m_mode = 0;   // 0 normal, 1 packet loop, 2 repeater
    int m_cnt  = 0;
    int g_v = 0, g_s = 0, g_e = 0, g_d = 0;
    int p1[4] = '{0, 0, 0, 0};
    int p2[4] = '{0, 0, 0, 0};
    int m_err = 0, m_vstb = 0, m_vcode = 0, m_disc = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cnt = 0; g_v = 0; g_s = 0; g_e = 0; g_d = 0;
            p1 = '{0, 0, 0, 0}; p2 = '{0, 0, 0, 0};
            m_err = 0; m_vstb = 0; m_vcode = 0;
        end else begin
            if (m_mode == 1) begin
                g_v = (m_cnt < LEN) ? 1 : 0;
                g_s = (m_cnt == 0) ? 1 : 0;
                g_e = (m_cnt == LEN - 1) ? 1 : 0;
                g_d = g_v ? ref_byte(m_cnt) : 0;
                m_cnt = (m_cnt + 1) % PER;
            end else begin
                g_v = 0; g_s = 0; g_e = 0; g_d = 0; m_cnt = 0;
            end
            p2 = p1;
            p1 = '{int'(up_valid), int'(up_sop), int'(up_eop), int'(up_data)};
            m_err = 0; m_vstb = 0;
            if (sel_wr) begin
                if (m_mode != 0)            m_err = 1;
                else if (sel_val == 8'h04)  m_mode = 1;
                else if (sel_val == 8'h05)  m_mode = 2;
                else if (sel_val >= 8'hC0) begin m_vstb = 1; m_vcode = int'(sel_val); end
                else                        m_err = 1;
            end
        end
        m_disc = int'(disc_in);
    end

    // compare every cycle, just after the edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            int ev, es, ee, ed;
            string ttag;
            if (m_mode == 1) begin ev = g_v; es = g_s; ee = g_e; ed = g_d; ttag = "R2"; end
            else if (m_mode == 2) begin ev = p2[0]; es = p2[1]; ee = p2[2]; ed = p2[3]; ttag = "R4"; end
            else begin ev = 0; es = 0; ee = 0; ed = 0; ttag = "R10"; end
            chk(ttag, "tx_valid", int'(tx_valid), ev);
            chk(ttag, "tx_sop", int'(tx_sop), es);
            chk(ttag, "tx_eop", int'(tx_eop), ee);
            chk(ttag, "tx_data", int'(tx_data), ed);
            chk("R3", "force_en", int'(force_en), (m_mode == 2) ? 1 : 0);
            chk("R5", "disc_status", int'(disc_status), m_disc);
            chk(cur_tag, "sel_err", int'(sel_err), m_err);
            chk("R7", "vend_stb", int'(vend_stb), m_vstb);
            chk("R7", "vend_code", int'(vend_code), m_vcode);
        end
    end

    task automatic write_sel(input logic [7:0] v, input string tag);
        @(negedge clk);
        cur_tag = tag;
        sel_wr = 1'b1; sel_val = v;
        @(negedge clk);
        sel_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_pkt(input int n, input int base, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            up_valid = 1'b1; up_sop = (i == 0); up_eop = (i == n - 1);
            up_data = 8'(base + i * 3);
            disc_in = (i % 3 == 1);
        end
        @(negedge clk);
        up_valid = 1'b0; up_sop = 1'b0; up_eop = 1'b0; up_data = 8'h00;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "tx_valid at reset", int'(tx_valid), 0);
        chk("R1", "force_en at reset", int'(force_en), 0);
        chk("R1", "sel_err at reset", int'(sel_err), 0);
        chk("R1", "vend_code at reset", int'(vend_code), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "tx_sop after reset", int'(tx_sop), 0);

        // R10: upstream traffic in normal mode is not forwarded
        send_pkt(5, 8'h10, 2);
        send_pkt(3, 8'h80, 0);
        send_pkt(4, 8'h33, 3);

        // R8 and R6 range edges, R7 vendor range
        write_sel(8'h00, "R8");
        write_sel(8'h03, "R8");
        write_sel(8'h40, "R8");
        write_sel(8'hBF, "R8");
        write_sel(8'h06, "R6");
        write_sel(8'h3F, "R6");
        write_sel(8'hC0, "R7");
        write_sel(8'hFF, "R7");
        write_sel(8'hD5, "R7");

        // R2: packet loop over several periods, upstream ignored
        write_sel(8'h04, "R2");
        send_pkt(6, 8'h21, 10);
        repeat (3 * PER) @(negedge clk);
        // R9: writes during a test mode are refused
        write_sel(8'h05, "R9");
        write_sel(8'hC0, "R9");
        write_sel(8'h00, "R9");
        repeat (PER) @(negedge clk);

        // only reset leaves the mode (R9)
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);

        // R3 and R4: repeater mode, back-to-back and gapped packets
        write_sel(8'h05, "R3");
        send_pkt(4, 8'h50, 0);
        send_pkt(1, 8'hE0, 0);
        send_pkt(7, 8'h07, 5);
        write_sel(8'h04, "R9");
        write_sel(8'hF0, "R9");
        send_pkt(3, 8'hA1, 4);
        repeat (4) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule